// File: doc/BRIEF.md
# Framing Pulse Synchronism Supervisor

This block supervises a serial-frame timing pair, a data clock and a once-per-frame framing pulse, for missing or surplus clock cycles. It counts data-clock periods between successive rising edges of the framing pulse, as seen on the rising clock edge. It then compares each measured period with the frame length implied by the configured number of 8-bit slots and by the clock-rate mode. In double-rate mode the data clock runs at twice the bit rate, so the frame holds twice as many clock periods.

The block reports a level status, synchronous or out of synchronism, and a one-cycle pulse whenever that status flips. Synchronism is granted only after two frames in a row have the right length. Any single wrong frame removes it at once, and so does a framing edge that arrives late. The supervisor is meant for systems where the framing pulse repeats once per frame. Where that is not true, the enable input is held low and the check is off.

Top module: `fsync_supervisor`

## Requirements
- R1: While reset is asserted and in the first cycle after its release, `in_sync` is 0 and `sync_irq` is 0.
- R2: The expected period is `slot_count` x 8 clock periods when `dbl_rate` is 0, and `slot_count` x 16 when `dbl_rate` is 1 (for example, 4 slots give 32 or 64). `slot_count` is an unsigned binary count of slots, from 4 to 128.
- R3: A framing edge is a rising-clock sample of `fp` equal to 1 whose previous sample was 0. The measured period is the number of clock rising edges from one framing edge to the next.
- R4: `in_sync` rises after two consecutive measured periods each equal the expected period. It becomes 1 in the cycle after the clock edge that samples the second closing framing edge.
- R5: A framing edge that closes a period longer or shorter than expected drives `in_sync` to 0 and clears the run of good periods. That edge still opens the next period.
- R6: When expected + 1 clock periods pass after a framing edge with no new framing edge, `in_sync` drops to 0 without waiting for an edge.
- R7: A change of `slot_count` or `dbl_rate` drives `in_sync` to 0 and clears the good-period run. The first framing edge after the change only opens a period.
- R8: `sync_irq` is high for exactly one cycle, in the same cycle that `in_sync` takes its new value, on every change of `in_sync` in either direction. It is low at all other times.
- R9: While `enable` is 0, `in_sync` is 0 and framing edges of any spacing have no effect. On re-enable, the first framing edge only opens a period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Data clock; all sampling on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| enable | input | 1 | 1 when the framing pulse repeats once per frame; 0 turns supervision off |
| fp | input | 1 | Framing pulse |
| slot_count | input | 8 | Slots per frame (4 to 128) |
| dbl_rate | input | 1 | 1 selects two clock periods per bit |
| in_sync | output | 1 | 1 = synchronous, 0 = loss of synchronism |
| sync_irq | output | 1 | One-cycle pulse on each change of `in_sync` |

## Verification
The bench aims at off-by-one frame lengths on both sides of the expected period. A counter that starts at the wrong value would grant synchronism on a period one cycle short or long, or refuse it on an exact one. The late-edge timeout is probed on the exact cycle before and after expected + 1, so a timeout one cycle early or late shows up as a wrong status at that cycle. It also applies a single-rate pulse train in double-rate mode, and changes the configuration and drops the enable while synchronous. A design that kept the old reference edge or a stale good-period run would regain synchronism one frame too early, or would never lose it.

// File: rtl/fsup_pkg.sv
package fsup_pkg;
  typedef enum logic {
    ST_LOSS = 1'b0,
    ST_SYNC = 1'b1
  } sync_state_e;

  // Bits needed to count up to a frame of max_slots slots at double rate, plus margin.
  function automatic int period_width(input int max_slots);
    return $clog2(max_slots * 16 + 2);
  endfunction
endpackage

// File: rtl/fsup_edge.sv
module fsup_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic fp,
  output logic fp_rise
);
  logic fp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fp_q <= 1'b0;
    else        fp_q <= fp;
  end

  assign fp_rise = fp & ~fp_q;
endmodule

// File: rtl/fsup_period_cnt.sv
module fsup_period_cnt #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             fp_rise,
  input  logic [CNT_W-1:0] exp_len,
  output logic             good_edge,
  output logic             bad_event
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ref_q, ref_d;
  logic             cnt_en;
  logic             closes_ok, closes_bad, late;

  always_comb begin
    cnt_d  = cnt_q;
    ref_d  = ref_q;
    cnt_en = 1'b0;
    if (clr) begin
      cnt_d  = '0;
      ref_d  = 1'b0;
      cnt_en = 1'b1;
    end else if (fp_rise) begin
      cnt_d  = CNT_W'(1);
      ref_d  = 1'b1;
      cnt_en = 1'b1;
    end else if (cnt_q != '1) begin
      cnt_d  = cnt_q + CNT_W'(1);
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ref_q <= 1'b0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
      ref_q <= ref_d;
    end
  end

  assign closes_ok  = fp_rise && ref_q && (cnt_q == exp_len);
  assign closes_bad = fp_rise && ref_q && (cnt_q != exp_len);
  assign late       = !fp_rise && ref_q && (cnt_q == exp_len + CNT_W'(1));
  assign good_edge  = !clr && closes_ok;
  assign bad_event  = !clr && (closes_bad || late);
endmodule

// File: rtl/fsup_sync_fsm.sv
module fsup_sync_fsm
  import fsup_pkg::*;
#(
  parameter int GOOD_NEEDED = 2,
  localparam int GW = $clog2(GOOD_NEEDED + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic good_edge,
  input  logic bad_event,
  output logic in_sync,
  output logic sync_irq
);
  sync_state_e st_q, st_d;
  logic [GW-1:0] good_q, good_d;
  logic          irq_q, irq_d;

  always_comb begin
    st_d   = st_q;
    good_d = good_q;
    if (clr || bad_event) begin
      st_d   = ST_LOSS;
      good_d = '0;
    end else if (good_edge) begin
      if (good_q != GW'(GOOD_NEEDED)) good_d = good_q + GW'(1);
      if (good_d == GW'(GOOD_NEEDED)) st_d = ST_SYNC;
    end
    irq_d = (st_d != st_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_LOSS;
      good_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      good_q <= good_d;
      irq_q  <= irq_d;
    end
  end

  assign in_sync  = (st_q == ST_SYNC);
  assign sync_irq = irq_q;
endmodule

// File: rtl/fsync_supervisor.sv
module fsync_supervisor
  import fsup_pkg::*;
#(
  parameter int MAX_SLOTS   = 128,
  parameter int GOOD_NEEDED = 2,
  localparam int SLOT_W = $clog2(MAX_SLOTS + 1),
  localparam int CNT_W  = period_width(MAX_SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              fp,
  input  logic [SLOT_W-1:0] slot_count,
  input  logic              dbl_rate,
  output logic              in_sync,
  output logic              sync_irq
);
  logic [SLOT_W:0]  cfg_q;
  logic             cfg_chg;
  logic             clr;
  logic [CNT_W-1:0] exp_len;
  logic             fp_rise;
  logic             good_edge, bad_event;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= {dbl_rate, slot_count};
  end

  assign cfg_chg = ({dbl_rate, slot_count} != cfg_q);
  assign clr     = !enable || cfg_chg;
  assign exp_len = dbl_rate ? (CNT_W'(slot_count) << 4) : (CNT_W'(slot_count) << 3);

  fsup_edge u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .fp      (fp),
    .fp_rise (fp_rise)
  );

  fsup_period_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr),
    .fp_rise   (fp_rise),
    .exp_len   (exp_len),
    .good_edge (good_edge),
    .bad_event (bad_event)
  );

  fsup_sync_fsm #(.GOOD_NEEDED(GOOD_NEEDED)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr),
    .good_edge (good_edge),
    .bad_event (bad_event),
    .in_sync   (in_sync),
    .sync_irq  (sync_irq)
  );
endmodule

// File: rtl/fsup_checker.sv
module fsup_checker #(
  parameter int SLOT_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              enable,
  input logic              fp,
  input logic [SLOT_W-1:0] slot_count,
  input logic              dbl_rate,
  input logic              in_sync,
  input logic              sync_irq
);
  always @(posedge clk) begin
    if (!rst_n) a_r1_reset_loss: assert (!in_sync && !sync_irq);
  end

  a_r8_irq_only_on_change: assert property (@(posedge clk) disable iff (!rst_n)
    sync_irq |-> (in_sync != $past(in_sync)));

  a_r8_change_raises_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (in_sync != $past(in_sync)) |-> sync_irq);

  a_r9_disabled_is_loss: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(enable) |-> !in_sync);

  a_r7_cfg_change_loss: assert property (@(posedge clk) disable iff (!rst_n)
    ((slot_count != $past(slot_count)) || (dbl_rate != $past(dbl_rate))) |=> !in_sync);

  a_r4_sync_after_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_sync) |-> ($past(fp) && !$past(fp, 2)));
endmodule

bind fsync_supervisor fsup_checker #(.SLOT_W(SLOT_W)) u_fsup_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .enable     (enable),
  .fp         (fp),
  .slot_count (slot_count),
  .dbl_rate   (dbl_rate),
  .in_sync    (in_sync),
  .sync_irq   (sync_irq)
);

// File: tb/fsync_supervisor_bench.sv
module fsync_supervisor_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 10;
  // slots, double rate, three period lengths, expected final status, expected status-change pulses
  localparam int V_SL[NV]  = '{4, 4, 4, 4, 4, 4, 5, 4, 128, 4};
  localparam int V_DB[NV]  = '{0, 1, 1, 0, 0, 0, 1, 0, 0, 0};
  localparam int V_L1[NV]  = '{32, 64, 32, 31, 32, 32, 80, 32, 1024, 32};
  localparam int V_L2[NV]  = '{32, 64, 32, 32, 32, 32, 80, 33, 1024, 31};
  localparam int V_L3[NV]  = '{32, 64, 32, 32, 33, 40, 80, 32, 1024, 32};
  localparam int V_SY[NV]  = '{1, 1, 0, 1, 0, 0, 1, 0, 1, 0};
  localparam int V_IR[NV]  = '{1, 1, 0, 1, 2, 2, 1, 0, 1, 0};

  logic       clk = 1'b0;
  logic       rst_n;
  logic       enable;
  logic       fp;
  logic [7:0] slot_count;
  logic       dbl_rate;
  logic       in_sync;
  logic       sync_irq;

  int n_chk = 0;
  int n_bad = 0;
  int irq_seen = 0;
  logic count_on = 1'b0;
  logic done = 1'b0;

  fsync_supervisor u_fsync_supervisor (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .fp         (fp),
    .slot_count (slot_count),
    .dbl_rate   (dbl_rate),
    .in_sync    (in_sync),
    .sync_irq   (sync_irq)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(posedge clk) if (count_on && sync_irq) irq_seen++;

  task automatic check(input string req, input int act, input int exp_v);
    n_chk++;
    if (act != exp_v) begin
      n_bad++;
      $display("FAIL %s: got %0d, want %0d", req, act, exp_v);
    end
  endtask

  task automatic pulse();
    fp = 1'b1;
    @(negedge clk);
    fp = 1'b0;
  endtask

  task automatic gap(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic restart(input int sl, input int db);
    enable = 1'b0;
    slot_count = 8'(sl);
    dbl_rate = 1'(db);
    gap(2);
    enable = 1'b1;
    gap(2);
  endtask

  initial begin
    rst_n = 1'b0; enable = 1'b0; fp = 1'b0; slot_count = 8'd4; dbl_rate = 1'b0;
    gap(3);
    check("R1 status in reset", int'(in_sync), 0);
    check("R1 pulse in reset", int'(sync_irq), 0);
    rst_n = 1'b1;
    gap(1);
    check("R1 status after release", int'(in_sync), 0);

    // R2 R3 R4 R5 R6: table of frame-length patterns
    for (int v = 0; v < NV; v++) begin
      restart(V_SL[v], V_DB[v]);
      irq_seen = 0;
      count_on = 1'b1;
      pulse();
      gap(V_L1[v] - 1); pulse();
      gap(V_L2[v] - 1); pulse();
      gap(V_L3[v] - 1); pulse();
      check($sformatf("R2/R4/R5/R6 vector %0d status", v), int'(in_sync), V_SY[v]);
      gap(1);
      count_on = 1'b0;
      check($sformatf("R8 vector %0d pulse count", v), irq_seen, V_IR[v]);
    end

    // R4 R8: gain sync, pulse exactly one cycle wide
    restart(4, 0);
    pulse(); gap(31); pulse(); gap(31); pulse();
    check("R4 sync after two good periods", int'(in_sync), 1);
    check("R8 pulse on gain", int'(sync_irq), 1);
    gap(1);
    check("R8 pulse one cycle", int'(sync_irq), 0);

    // R6: late edge drops sync at expected+1 exactly
    gap(31);
    check("R6 still sync at expected", int'(in_sync), 1);
    gap(1);
    check("R6 loss at expected+1", int'(in_sync), 0);
    check("R8 pulse on loss", int'(sync_irq), 1);

    // R7: configuration change while synchronous
    pulse(); gap(31); pulse(); gap(31); pulse();
    check("R4 resync", int'(in_sync), 1);
    dbl_rate = 1'b1;
    gap(1);
    check("R7 loss on config change", int'(in_sync), 0);
    pulse(); gap(63); pulse();
    check("R7 first edge only opens period", int'(in_sync), 0);
    gap(63); pulse();
    check("R2 double rate sync", int'(in_sync), 1);

    // R9: disable drops sync, edges ignored while disabled
    enable = 1'b0;
    gap(1);
    check("R9 loss when disabled", int'(in_sync), 0);
    pulse(); gap(63); pulse(); gap(63); pulse(); gap(63); pulse();
    check("R9 edges ignored while disabled", int'(in_sync), 0);
    enable = 1'b1;
    gap(2);
    pulse(); gap(63); pulse();
    check("R9 re-enable needs fresh reference", int'(in_sync), 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got hung run, want completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule